// File: doc/BRIEF.md
# Split-Access 64-bit Time Base Counter

The block keeps a free-running 64-bit time value that software sees as two 32-bit halves on a small register bus. A fixed prescaler turns the core clock into a count pulse, one pulse every `DIV` core cycles (eight by default, so a 1 GHz core gives a 125 MHz count). A strap input picks how the count moves on each pulse. With the strap low, the two halves form one plain binary counter. With the strap high, the lower half counts nanoseconds, returns to zero after 999,999,999, and carries one second into the upper half.

Software reads the upper half first. That read also copies the live lower half into a shadow register, and a read of the lower-half address then returns that copy, so the two reads make one consistent 64-bit sample. A second read address returns the live lower half for software that uses the retry method: read upper, read lower, read upper again, and repeat if the two upper values differ. To load a new time without a stray carry, software writes zero to the lower half, then writes the upper half, then writes the lower half. A write lands on the next clock, and a count pulse that falls in the same cycle as a write is discarded.

Top module: `time_base_counter`

## Requirements
- R1: While `rst_n` is low, both halves, the shadow register and the prescaler are zero. Reads of every address return 0 after reset and before the first count pulse.
- R2: A count pulse occurs once every `DIV` clock cycles (default 8). The first pulse comes in the `DIV`-th cycle after reset release. Without a pulse or a write, neither half changes.
- R3: With `ns_mode` low, a pulse adds one to the 64-bit value. The lower half wraps from 0xFFFFFFFF to 0 and carries into the upper half. The upper half wraps from 0xFFFFFFFF to 0 with no other effect.
- R4: With `ns_mode` high, a pulse adds one to the lower half while it is below 999,999,999. At 999,999,999 or any larger written value, the pulse sets the lower half to 0 and adds one to the upper half.
- R5: `bus_addr` 0 reads and writes the upper half. Address 1 writes the lower half and reads the shadow copy. Address 2 reads the live lower half. Address 3 reads 0. Writes to addresses 2 and 3 have no effect.
- R6: A cycle with `bus_rd` high and `bus_addr` 0 copies the live lower half into the shadow register at the clock edge. The shadow keeps that value until the next such read.
- R7: A write changes only the addressed half and is visible from the next clock edge. A count pulse in the same cycle as a write is dropped.
- R8: The load sequence of lower 0, then upper U, then lower L leaves the value at exactly U:L, whatever the lower half held before.
- R9: A change of `ns_mode` governs the next count pulse. The stored value is not touched at the moment of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset. The environment asserts and releases it synchronously to `clk`. |
| ns_mode | input | 1 | Strap: 1 selects seconds/nanoseconds counting, 0 selects binary counting |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe. Needed only for the snapshot side effect. |
| bus_addr | input | 2 | Register address (0 upper, 1 lower/shadow, 2 live lower, 3 unused) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` in the same cycle |

## Verification
A fault in the prescaler shows within at most `DIV` cycles as a count pulse that comes early, late or twice. A wrong wrap or carry path stays hidden until the lower half reaches its limit, so the bench writes values a few counts short of each limit to make the error visible within tens of cycles. A shadow register that is loaded at the wrong time, or not held, appears on the next address-1 read as a value that differs from the live lower half sampled at the upper read. The model tracks all of this state on every cycle, so any port difference is reported on the cycle it appears.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

  typedef enum logic [1:0] {
    TBC_A_UPPER = 2'd0,
    TBC_A_SNAP  = 2'd1,
    TBC_A_LIVE  = 2'd2,
    TBC_A_NONE  = 2'd3
  } tbc_addr_e;

  localparam int unsigned TBC_NS_LAST = 32'd999_999_999;

endpackage

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      assign tick = (cnt_q == LAST);

      always_comb begin
        if (tick) cnt_d = '0;
        else      cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R2: the divider count never leaves its range
      p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

      // R2: pulses never come on consecutive cycles
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/tbc_count.sv
module tbc_count #(
  parameter int          HALF_W  = 32,
  parameter int unsigned NS_LAST = 999_999_999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ns_mode,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] hi_q,
  output logic [HALF_W-1:0] lo_q
);

  localparam int FULL_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] NS_TOP = HALF_W'(NS_LAST);

  logic [HALF_W-1:0] hi_d;
  logic [HALF_W-1:0] lo_d;
  logic [FULL_W-1:0] bin_sum;
  logic              load_en;

  assign bin_sum = {hi_q, lo_q} + 1'b1;

  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    load_en = 1'b0;
    if (wr_hi) begin
      hi_d    = wdata;
      load_en = 1'b1;
    end else if (wr_lo) begin
      lo_d    = wdata;
      load_en = 1'b1;
    end else if (tick) begin
      load_en = 1'b1;
      if (ns_mode) begin
        if (lo_q >= NS_TOP) begin
          lo_d = '0;
          hi_d = hi_q + 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end else begin
        hi_d = bin_sum[FULL_W-1:HALF_W];
        lo_d = bin_sum[HALF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R2: no pulse and no write leaves the value alone
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_hi && !wr_lo) |=> ($stable(lo_q) && $stable(hi_q)));

  // R3: binary lower wrap carries into the upper half
  p_bin_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_hi && !wr_lo && !ns_mode && (lo_q == '1))
      |=> (lo_q == '0 && hi_q == $past(hi_q) + 1'b1));

  // R4: nanosecond limit wraps to zero and bumps seconds
  p_ns_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_hi && !wr_lo && ns_mode && (lo_q >= NS_TOP))
      |=> (lo_q == '0 && hi_q == $past(hi_q) + 1'b1));

  // R4: below the limit only the lower half steps
  p_ns_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_hi && !wr_lo && ns_mode && (lo_q < NS_TOP))
      |=> (lo_q == $past(lo_q) + 1'b1 && $stable(hi_q)));

  // R7: an upper write wins over a coincident pulse
  p_wr_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hi_q == $past(wdata) && $stable(lo_q)));

  // R7: a lower write wins over a coincident pulse
  p_wr_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata) && $stable(hi_q)));

endmodule

// File: rtl/tbc_regif.sv
module tbc_regif
  import tbc_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [HALF_W-1:0] hi_q,
  input  logic [HALF_W-1:0] lo_q,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic [HALF_W-1:0] rdata
);

  tbc_addr_e         sel;
  logic [HALF_W-1:0] shadow_q;
  logic [HALF_W-1:0] shadow_d;
  logic              snap_en;

  assign sel     = tbc_addr_e'(bus_addr);
  assign wr_hi   = bus_wr && (sel == TBC_A_UPPER);
  assign wr_lo   = bus_wr && (sel == TBC_A_SNAP);
  assign snap_en = bus_rd && (sel == TBC_A_UPPER);
  assign shadow_d = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= '0;
    else if (snap_en) shadow_q <= shadow_d;
  end

  always_comb begin
    unique case (sel)
      TBC_A_UPPER: rdata = hi_q;
      TBC_A_SNAP:  rdata = shadow_q;
      TBC_A_LIVE:  rdata = lo_q;
      default:     rdata = '0;
    endcase
  end

  // R6: an upper read captures the lower half seen in that cycle
  p_snap_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (shadow_q == $past(lo_q)));

  // R6: without an upper read the shadow holds
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(shadow_q));

endmodule

// File: rtl/time_base_counter.sv
module time_base_counter #(
  parameter int          DIV     = 8,
  parameter int          HALF_W  = 32,
  parameter int unsigned NS_LAST = tbc_pkg::TBC_NS_LAST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ns_mode,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata
);

  logic              tick;
  logic              wr_hi;
  logic              wr_lo;
  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] lo_q;

  tbc_prescaler #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  tbc_count #(.HALF_W(HALF_W), .NS_LAST(NS_LAST)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .ns_mode(ns_mode),
    .wr_hi  (wr_hi),
    .wr_lo  (wr_lo),
    .wdata  (bus_wdata),
    .hi_q   (hi_q),
    .lo_q   (lo_q)
  );

  tbc_regif #(.HALF_W(HALF_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .rdata   (bus_rdata)
  );

  // R5: writes never reach both halves at once
  p_one_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_hi, wr_lo}));

endmodule

// File: tb/test_time_base_counter.sv
module test_time_base_counter;

  logic        clk;
  logic        rst_n;
  logic        ns_mode;
  logic        bus_wr;
  logic        bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_total;
  int n_fail;
  string phase;

  // reference model state
  logic [31:0] m_hi, m_lo, m_sh;
  int          m_pc;
  logic        m_tick;
  logic [63:0] m_full;

  time_base_counter i_time_base_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .ns_mode  (ns_mode),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_sh = 0; m_pc = 0;
    end else begin
      m_tick = (m_pc == 7);
      m_pc   = m_tick ? 0 : m_pc + 1;
      if (bus_rd && bus_addr == 2'd0) m_sh = m_lo;
      if (bus_wr && bus_addr == 2'd0)      m_hi = bus_wdata;
      else if (bus_wr && bus_addr == 2'd1) m_lo = bus_wdata;
      else if (m_tick) begin
        if (ns_mode) begin
          if (m_lo >= 32'd999_999_999) begin m_lo = 0; m_hi = m_hi + 1; end
          else m_lo = m_lo + 1;
        end else begin
          m_full = {m_hi, m_lo} + 64'd1;
          m_hi = m_full[63:32];
          m_lo = m_full[31:0];
        end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_hi;
      2'd1:    return m_sh;
      2'd2:    return m_lo;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic ok,
                     input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n)
      chk(phase, bus_rdata == m_read(bus_addr), bus_rdata, m_read(bus_addr));
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] u, input logic [31:0] l);
    wr(2'd1, 32'd0);
    wr(2'd0, u);
    wr(2'd1, l);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, s1;
    n_total = 0; n_fail = 0; phase = "R1 reset";
    rst_n = 1'b0; ns_mode = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = 2'd2; bus_wdata = '0;
    idle(3);
    #1 rst_n = 1'b1;
    // R1: zeros right after release
    rd(2'd0, v);  chk("R1 upper", v == 0, v, 0);
    rd(2'd1, v);  chk("R1 shadow", v == 0, v, 0);

    // R2: steady pulse rate
    phase = "R2 count";
    rd(2'd2, v);
    idle(78);
    rd(2'd2, v2);
    chk("R2 rate", (v2 - v) >= 9 && (v2 - v) <= 11, v2 - v, v + 10);

    // R8: three-step load
    phase = "R8 load";
    wr(2'd1, 32'hFFFF_FFF0);
    load(32'h0000_1234, 32'hABCD_0000);
    rd(2'd0, v); chk("R8 upper", v == 32'h1234, v, 32'h1234);
    rd(2'd1, v); chk("R8 lower", v - 32'hABCD_0000 <= 1, v, 32'hABCD_0000);

    // R3: binary carry and upper wrap
    phase = "R3 binary";
    load(32'd5, 32'hFFFF_FFFD);
    idle(40);
    rd(2'd0, v); chk("R3 carry", v == 32'd6, v, 32'd6);
    load(32'hFFFF_FFFF, 32'hFFFF_FFFE);
    idle(30);
    rd(2'd0, v); chk("R3 upper wrap", v == 32'd0, v, 32'd0);

    // R9 and R4: switch strap, nanosecond wrap
    phase = "R9 mode";
    ns_mode = 1'b1;
    idle(20);
    phase = "R4 ns";
    load(32'd7, 32'd999_999_997);
    idle(40);
    rd(2'd0, v);  chk("R4 seconds", v == 32'd8, v, 32'd8);
    rd(2'd1, v);  chk("R4 nanos", v < 32'd10, v, 32'd0);
    wr(2'd1, 32'hF000_0000);
    idle(12);
    rd(2'd0, v);  chk("R4 over limit", v == 32'd9, v, 32'd9);
    rd(2'd2, v);  chk("R4 over limit lo", v < 32'd3, v, 32'd0);

    // R9: back to binary
    phase = "R9 mode back";
    ns_mode = 1'b0;
    load(32'd0, 32'd999_999_998);
    idle(30);
    rd(2'd0, v); chk("R9 binary again", v == 32'd0, v, 32'd0);

    // R6: snapshot capture and hold
    phase = "R6 shadow";
    rd(2'd0, v);
    rd(2'd1, s1);
    idle(50);
    rd(2'd1, v2); chk("R6 hold", v2 == s1, v2, s1);
    rd(2'd2, v);  chk("R6 live moved", v != s1, v, s1);

    // R7: held write drops every pulse
    phase = "R7 write";
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h100;
    repeat (20) @(negedge clk);
    #1 bus_wr = 1'b0; bus_addr = 2'd2;
    #5 chk("R7 dropped", bus_rdata == 32'h100 || bus_rdata == 32'h101,
           bus_rdata, 32'h100);
    wr(2'd0, 32'hCAFE);
    rd(2'd0, v); chk("R7 upper", v == 32'hCAFE, v, 32'hCAFE);

    // R5: unused addresses
    phase = "R5 decode";
    wr(2'd3, 32'hDEAD_BEEF);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd3, v); chk("R5 addr3", v == 0, v, 0);
    rd(2'd0, v); chk("R5 upper kept", v == 32'hCAFE, v, 32'hCAFE);
    idle(20);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule